// File: doc/BRIEF.md
# Multi-Input Pattern Condition Evaluator

This block watches a wide vector of sampled signals and turns it into a small set of boolean conditions. The signals are compared against up to four match groups. Each group gives two results: an AND-reduced result and an OR-reduced result. In each group, every input bit has a 2-bit select mode. The mode either requires the bit to be 0, requires it to be 1, or leaves the bit out of the reduction.

Each condition has one 32-bit decode word. The word chooses which sources take part in the condition and what value each source must have. The sources are the group AND results, the group OR results, a timer-compare flag and a counter-compare flag. The condition is true only when every chosen source has its required value. A final bit can invert the result.

The sampled vector, both flags and all configuration words are captured together on one clock edge. The condition outputs are then combinational from that captured state. A step sequencer reads them one clock after the sample.

Top module: `cond_eval`

## Requirements
- R1: An input whose select is 2'b11 counts as true when the input is 1. An input whose select is 2'b10 counts as true when the input is 0. That true/false term feeds both the group's AND reduction and its OR reduction.
- R2: Selects 2'b00 and 2'b01 both leave the input out of the result. Such an input gives 1 to the AND reduction and 0 to the OR reduction. A group in which every input is left out therefore reports AND = 1 and OR = 0.
- R3: Input i of group g takes its select from bits [4k+1:4k] of match word w, where w = i/8 and k = i%8. Match word w of group g sits at match_cfg_i[(g*NWORDS+w)*32 +: 32], with NWORDS = ceil(NUM_IN/8). Bits [4k+3:4k+2] of every word have no effect.
- R4: Select slots for input positions at or above NUM_IN are ignored.
- R5: In decode word bits for group n: bit 4n+1 includes the group's AND result and bit 4n gives its required value. Bit 4n+3 includes the group's OR result and bit 4n+2 gives its required value.
- R6: In the decode word, bit 17 includes the timer flag and bit 16 gives its required value. Bit 21 includes the counter flag and bit 20 gives its required value.
- R7: A condition is true when at least one source is included and every included source equals its required value. A decode word with no included source gives false.
- R8: Decode bit 24 inverts the condition result.
- R9: cond_o reflects the samples, flags and configuration captured at the most recent rising clock edge. A new input value has no effect on cond_o before that edge.
- R10: While rst_ni is low, and until the first capture after it rises, cond_o is all zero, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_i | input | NUM_IN | Sampled signal vector |
| tmr_hit_i | input | 1 | Timer comparator flag |
| cnt_hit_i | input | 1 | Counter comparator flag |
| match_cfg_i | input | NUM_GRP*NWORDS*32 | Match words of all groups, packed group-major |
| decode_cfg_i | input | NUM_COND*32 | One decode word per condition, condition c at [32c +: 32] |
| cond_o | output | NUM_COND | One result bit per condition |

## Verification
The bench builds the block with these parameters:
- NUM_IN = 20, which gives three match words per group. The top half of the last word has no inputs behind it, so the ignored out-of-range slots can be loaded with sense-0 selects and shown to have no effect.
- All four groups. One group is left fully bypassed, which exercises the constant AND = 1 / OR = 0 case.
- NUM_COND = 2, so two conditions with different source mixes are checked on the same captured samples.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

    typedef enum logic [1:0] {
        SEL_PASS_OR  = 2'b00,
        SEL_PASS_AND = 2'b01,
        SEL_WANT0    = 2'b10,
        SEL_WANT1    = 2'b11
    } sel_mode_e;

    localparam int CFG_WORD      = 32;
    localparam int SELS_PER_WORD = 8;
    localparam int SEL_STRIDE    = 4;

    localparam int DEC_TMR_HI  = 16;
    localparam int DEC_TMR_ACT = 17;
    localparam int DEC_CNT_HI  = 20;
    localparam int DEC_CNT_ACT = 21;
    localparam int DEC_INV     = 24;

    // returns {and_term, or_term} for one input bit
    function automatic logic [1:0] sel_terms(sel_mode_e mode, logic bit_in);
        logic [1:0] t;
        case (mode)
            SEL_PASS_OR,
            SEL_PASS_AND: t = 2'b10;
            SEL_WANT0:    t = {~bit_in, ~bit_in};
            default:      t = {bit_in, bit_in};
        endcase
        return t;
    endfunction

endpackage

// File: rtl/grp_match.sv
module grp_match
    import cond_eval_pkg::*;
#(
    parameter int NUM_IN = 140,
    parameter int NWORDS = (NUM_IN + 7) / 8
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [NUM_IN-1:0]            sample_i,
    input  logic [NWORDS*CFG_WORD-1:0]   cfg_i,
    output logic                         and_o,
    output logic                         or_o
);

    logic [NUM_IN-1:0] and_v;
    logic [NUM_IN-1:0] or_v;
    logic [NUM_IN-1:0] sense_v;
    logic              cfg_unused;

    // padding bits of each nibble and slots past NUM_IN carry no meaning
    assign cfg_unused = ^cfg_i;

    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_bit
        localparam int BASE = (gi / SELS_PER_WORD) * CFG_WORD
                            + (gi % SELS_PER_WORD) * SEL_STRIDE;
        logic [1:0] terms;
        assign terms       = sel_terms(sel_mode_e'(cfg_i[BASE +: 2]), sample_i[gi]);
        assign and_v[gi]   = terms[1];
        assign or_v[gi]    = terms[0];
        assign sense_v[gi] = cfg_i[BASE + 1];
    end

    assign and_o = &and_v;
    assign or_o  = |or_v;

    // R2: a fully bypassed group is AND-true and OR-false
    a_r2_all_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|sense_v) |-> (and_o && !or_o));

    // R1: the OR tree can only fire through a sensing input
    a_r1_or_needs_sense: assert property (@(posedge clk_i) disable iff (!rst_ni)
        or_o |-> (|sense_v));

endmodule

// File: rtl/cond_decode.sv
module cond_decode
    import cond_eval_pkg::*;
#(
    parameter int NUM_GRP = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_GRP-1:0]  grp_and_i,
    input  logic [NUM_GRP-1:0]  grp_or_i,
    input  logic                tmr_hit_i,
    input  logic                cnt_hit_i,
    input  logic [CFG_WORD-1:0] dec_i,
    output logic                cond_o
);

    localparam int NSRC = 2 * NUM_GRP + 2;

    logic [NSRC-1:0] act;
    logic [NSRC-1:0] want;
    logic [NSRC-1:0] val;
    logic            hit;
    logic            dec_unused;

    assign dec_unused = ^dec_i;

    for (genvar n = 0; n < NUM_GRP; n++) begin : g_src
        assign act[2*n]    = dec_i[4*n + 1];
        assign want[2*n]   = dec_i[4*n];
        assign val[2*n]    = grp_and_i[n];
        assign act[2*n+1]  = dec_i[4*n + 3];
        assign want[2*n+1] = dec_i[4*n + 2];
        assign val[2*n+1]  = grp_or_i[n];
    end

    assign act[NSRC-2]  = dec_i[DEC_TMR_ACT];
    assign want[NSRC-2] = dec_i[DEC_TMR_HI];
    assign val[NSRC-2]  = tmr_hit_i;
    assign act[NSRC-1]  = dec_i[DEC_CNT_ACT];
    assign want[NSRC-1] = dec_i[DEC_CNT_HI];
    assign val[NSRC-1]  = cnt_hit_i;

    assign hit    = (|act) && (&(~act | ~(val ^ want)));
    assign cond_o = hit ^ dec_i[DEC_INV];

    // R7: with nothing included only the inversion bit shows
    a_r7_empty_false: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act == '0) |-> (cond_o == dec_i[DEC_INV]));

    // R7/R8: one included source off its polarity forces the pre-inversion result low
    a_r8_mismatch_inverts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((act & (val ^ want)) != '0) |-> (cond_o == dec_i[DEC_INV]));

endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import cond_eval_pkg::*;
#(
    parameter int NUM_IN   = 140,
    parameter int NUM_GRP  = 4,
    parameter int NUM_COND = 4
) (
    input  logic                                       clk_i,
    input  logic                                       rst_ni,
    input  logic [NUM_IN-1:0]                          sample_i,
    input  logic                                       tmr_hit_i,
    input  logic                                       cnt_hit_i,
    input  logic [NUM_GRP*((NUM_IN+7)/8)*32-1:0]       match_cfg_i,
    input  logic [NUM_COND*32-1:0]                     decode_cfg_i,
    output logic [NUM_COND-1:0]                        cond_o
);

    localparam int NWORDS    = (NUM_IN + 7) / 8;
    localparam int GRP_CFG_W = NWORDS * CFG_WORD;
    localparam int MATCH_W   = NUM_GRP * GRP_CFG_W;
    localparam int DEC_W     = NUM_COND * CFG_WORD;

    typedef struct packed {
        logic [NUM_IN-1:0]  sample;
        logic               tmr;
        logic               cnt;
        logic [MATCH_W-1:0] match;
        logic [DEC_W-1:0]   dec;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d        = cap_q;
        cap_d.sample = sample_i;
        cap_d.tmr    = tmr_hit_i;
        cap_d.cnt    = cnt_hit_i;
        cap_d.match  = match_cfg_i;
        cap_d.dec    = decode_cfg_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    logic [NUM_GRP-1:0] grp_and;
    logic [NUM_GRP-1:0] grp_or;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        grp_match #(
            .NUM_IN (NUM_IN),
            .NWORDS (NWORDS)
        ) i_grp_match (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .sample_i (cap_q.sample),
            .cfg_i    (cap_q.match[g*GRP_CFG_W +: GRP_CFG_W]),
            .and_o    (grp_and[g]),
            .or_o     (grp_or[g])
        );
    end

    for (genvar c = 0; c < NUM_COND; c++) begin : g_cond
        cond_decode #(
            .NUM_GRP (NUM_GRP)
        ) i_cond_decode (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .grp_and_i (grp_and),
            .grp_or_i  (grp_or),
            .tmr_hit_i (cap_q.tmr),
            .cnt_hit_i (cap_q.cnt),
            .dec_i     (cap_q.dec[c*CFG_WORD +: CFG_WORD]),
            .cond_o    (cond_o[c])
        );
    end

    // R9: unchanged inputs across a capture leave the conditions unchanged
    a_r9_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $stable(sample_i) && $stable(tmr_hit_i) && $stable(cnt_hit_i)
         && $stable(match_cfg_i) && $stable(decode_cfg_i)) |=> $stable(cond_o));

endmodule

// File: tb/test_cond_eval.sv
module test_cond_eval;

    localparam int NI = 20;
    localparam int NG = 4;
    localparam int NC = 2;
    localparam int NW = (NI + 7) / 8;
    localparam int MW = NG * NW * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] sample = '0;
    logic          tmr = 1'b0;
    logic          cnt = 1'b0;
    logic [MW-1:0] mcfg = '0;
    logic [NC*32-1:0] dcfg = '0;
    logic [NC-1:0] cond;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    cond_eval #(.NUM_IN(NI), .NUM_GRP(NG), .NUM_COND(NC)) i_cond_eval (
        .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .tmr_hit_i(tmr),
        .cnt_hit_i(cnt), .match_cfg_i(mcfg), .decode_cfg_i(dcfg), .cond_o(cond)
    );

    // {expected cond[1:0], cnt, tmr, sample[19:0]}
    localparam logic [23:0] TBL [7] = '{
        {2'b01, 1'b0, 1'b0, 20'h0000A},
        {2'b10, 1'b0, 1'b1, 20'h0000B},
        {2'b00, 1'b0, 1'b0, 20'h0000B},
        {2'b01, 1'b0, 1'b1, 20'h0000A},
        {2'b00, 1'b0, 1'b1, 20'h00005},
        {2'b01, 1'b0, 1'b1, 20'hF00FA},
        {2'b10, 1'b0, 1'b1, 20'h3C00B}
    };

    task automatic check(input logic [NC-1:0] exp, input string tag);
        n_chk++;
        if (cond !== exp) begin
            n_err++;
            $display("FAIL %s: cond_o=%b expected %b", tag, cond, exp);
        end
    endtask

    task automatic set_word(input int g, input int w, input logic [31:0] v);
        mcfg[(g*NW + w)*32 +: 32] = v;
    endtask

    task automatic step(input logic [NI-1:0] s, input logic t, input logic c,
                        input logic [NC-1:0] exp, input string tag);
        @(negedge clk);
        sample = s; tmr = t; cnt = c;
        @(posedge clk);
        #1;
        check(exp, tag);
    endtask

    initial begin
        // group 0: 1010 on inputs 3..0; group 1: 1011; rest bypass-for-AND
        set_word(0, 0, 32'h11113232); set_word(0, 1, 32'h11111111); set_word(0, 2, 32'h11111111);
        set_word(1, 0, 32'h11113233); set_word(1, 1, 32'h11111111); set_word(1, 2, 32'h11111111);
        // group 2: sense 1 on inputs 19..16, sense 0 in the slots past NUM_IN
        set_word(2, 2, 32'h22223333);
        // group 3: everything bypass-for-OR
        dcfg[0 +: 32]  = 32'h00000003;
        dcfg[32 +: 32] = 32'h00030030;
        sample = 20'h0000A;

        // R10: zero during reset even though condition 0 would match
        #1;  check(2'b00, "R10 reset t0");
        repeat (3) @(posedge clk);
        #1;  check(2'b00, "R10 during reset");
        @(negedge clk); rst_n = 1'b1;
        #1;  check(2'b00, "R10 before first capture");
        @(posedge clk); #1;
        check(2'b01, "R10 first capture");

        // R1 R3 R5 R6 R7: table walk
        for (int i = 0; i < 7; i++) begin
            step(TBL[i][19:0], TBL[i][20], TBL[i][21], TBL[i][23:22],
                 $sformatf("R1/R5 table row %0d", i));
        end

        // R5 OR of group 2, R4 ignored slots
        dcfg[0 +: 32] = 32'h00000C00; dcfg[32 +: 32] = '0;
        step(20'h10000, 0, 0, 2'b01, "R5 group2 OR high");
        step(20'h00000, 0, 0, 2'b00, "R4 out-of-range slots ignored (OR)");
        dcfg[0 +: 32] = 32'h00000300;
        step(20'hF0000, 0, 0, 2'b01, "R4 group2 AND all ones");
        step(20'h70000, 0, 0, 2'b00, "R1 group2 AND one zero");

        // R2 fully bypassed group 3
        dcfg[0 +: 32] = 32'h0000B000;
        step(20'hFFFFF, 0, 0, 2'b01, "R2 bypass AND=1 OR=0");
        dcfg[0 +: 32] = 32'h0000C000;
        step(20'hFFFFF, 0, 0, 2'b00, "R2 bypass OR never 1");

        // R7 required-low polarity and empty decode
        dcfg[0 +: 32] = 32'h00000002;
        step(20'h0000A, 0, 0, 2'b00, "R7 AND required low, AND=1");
        step(20'h00005, 0, 0, 2'b01, "R7 AND required low, AND=0");
        dcfg[0 +: 32] = '0;
        step(20'h0000A, 1, 1, 2'b00, "R7 no source is false");

        // R8 inversion
        dcfg[0 +: 32] = 32'h01000000;
        step(20'h0000A, 0, 0, 2'b01, "R8 invert empty");
        dcfg[0 +: 32] = 32'h01000003;
        step(20'h0000A, 0, 0, 2'b00, "R8 invert match");
        step(20'h00005, 0, 0, 2'b01, "R8 invert miss");

        // R6 counter and timer polarity
        dcfg[0 +: 32] = '0; dcfg[32 +: 32] = 32'h00300000;
        step(20'h0, 0, 1, 2'b10, "R6 counter high");
        step(20'h0, 0, 0, 2'b00, "R6 counter high, flag low");
        dcfg[32 +: 32] = 32'h00200000;
        step(20'h0, 0, 0, 2'b10, "R6 counter low");
        dcfg[32 +: 32] = 32'h00020000;
        step(20'h0, 0, 0, 2'b10, "R6 timer low");
        step(20'h0, 1, 0, 2'b00, "R6 timer low, flag high");

        // R3 padding bits in each nibble have no effect
        set_word(0, 0, 32'h5555FEFE);
        dcfg[0 +: 32] = 32'h00000003; dcfg[32 +: 32] = '0;
        step(20'h0000A, 0, 0, 2'b01, "R3 padding bits ignored, match");
        step(20'h0000B, 0, 0, 2'b00, "R3 padding bits ignored, miss");

        // R9 latency
        @(negedge clk); sample = 20'h0000A;
        #1; check(2'b00, "R9 no change before edge");
        @(posedge clk); #1;
        check(2'b01, "R9 change after edge");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

endmodule